// File: doc/BRIEF.md
# Dual reloadable down-counter timer

Two independent 16-bit down-counters share one control register. Each channel has its own mode bit and its own tick-select bit. In free-running mode a channel that counts down past zero wraps to all ones and keeps counting. In prescale mode it reloads the value most recently written for it, so it acts as a periodic divider. Both modes raise a one-cycle underflow pulse.

A counter moves only on clock cycles where its selected tick enable is high. The select bit chooses between two sources. One is the reference tick as it arrives. The other is that tick divided by 256, taken from an 8-bit prescaler that both channels share. Software uses one write port and one combinational read port. The write port sets the control word and each channel's load value. The read port returns the control word and the load values. Each counter also has its own live output and underflow pulse.

Top module: `dual_timer`

## Requirements
- R1: After reset both counters read 0, both underflow pulses are low, the control word reads 0 and both load values read 0.
- R2: Address 0 holds the 8-bit control word, which reads back zero-extended. Address 1 holds the load value of channel A and address 2 that of channel B. Address 3 reads 0.
- R3: A write to a channel's load address sets the load value and the counter on the same clock edge. It raises no underflow pulse, and it takes priority over a tick on that edge.
- R4: Control bit 5 selects channel A's tick and bit 7 selects channel B's. The value 1 takes the reference tick directly, so the counter decrements once per high reference tick.
- R5: A select value of 0 makes the channel decrement once per 256 reference ticks. This happens on the reference tick where the shared 8-bit prescaler, cleared by reset and advanced by each reference tick, equals 255.
- R6: On a cycle with no selected tick and no load write, a counter holds its value.
- R7: Control bit 4 (channel A) and bit 6 (channel B) set the mode. When the bit is 0 (free-running), a tick at count 0 gives 0xFFFF and a one-cycle underflow pulse.
- R8: When the mode bit is 1 (prescale), a tick at count 0 reloads the last written load value and gives a one-cycle underflow pulse.
- R9: An underflow pulse is high only for the cycle after an edge on which a counter at 0 took a tick.
- R10: The two channels run independently and may be in different modes at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational |
| count_a | output | 16 | Channel A counter |
| count_b | output | 16 | Channel B counter |
| uf_a | output | 1 | Channel A underflow pulse |
| uf_b | output | 1 | Channel B underflow pulse |

## Verification
Counters, load values, the control word and the underflow pulses are all registered. A write or tick applied before a rising edge therefore shows at the outputs right after that edge. The bench drives each stimulus at a falling edge, lets exactly one rising edge pass, and compares at the next falling edge. Register reads are combinational, so they are compared at the falling edge where the read address was set. The divide-by-256 path is checked by counting 255 reference ticks with no change and then expecting the decrement on the 256th.

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  output logic [CW-1:0] count_a,
  output logic [CW-1:0] count_b,
  output logic          uf_a,
  output logic          uf_b
);
  localparam int NCH = 2;
  localparam int CTW = 8;

  logic [CTW-1:0] ctrl_q;
  logic [PW-1:0]  pre_q;
  logic           slow_tick;

  assign slow_tick = ref_tick && (pre_q == '1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pre_q <= '0;
    else if (ref_tick) pre_q <= pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          ctrl_q <= '0;
    else if (wr_en && wr_addr == 2'd0)   ctrl_q <= wr_data[CTW-1:0];

  for (genvar g = 0; g < NCH; g++) begin : ch
    localparam int MODE_BIT = 4 + 2 * g;
    localparam int SEL_BIT  = 5 + 2 * g;
    logic [CW-1:0] cnt, ld;
    logic          uf, tick, load_wr;

    assign tick    = ctrl_q[SEL_BIT] ? ref_tick : slow_tick;
    assign load_wr = wr_en && (wr_addr == 2'(g + 1));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        ld  <= '0;
        uf  <= 1'b0;
      end else begin
        uf <= 1'b0;
        if (load_wr) begin
          ld  <= wr_data;
          cnt <= wr_data;
        end else if (tick) begin
          if (cnt == '0) begin
            uf  <= 1'b1;
            cnt <= ctrl_q[MODE_BIT] ? ld : '1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
  end

  assign count_a = ch[0].cnt;
  assign count_b = ch[1].cnt;
  assign uf_a    = ch[0].uf;
  assign uf_b    = ch[1].uf;

  always_comb
    case (rd_addr)
      2'd0:    rd_data = {{(CW-CTW){1'b0}}, ctrl_q};
      2'd1:    rd_data = ch[0].ld;
      2'd2:    rd_data = ch[1].ld;
      default: rd_data = '0;
    endcase
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_tick,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [CW-1:0] wr_data,
  input logic [7:0]    ctrl,
  input logic [CW-1:0] count_a,
  input logic [CW-1:0] count_b,
  input logic          uf_a,
  input logic          uf_b
);
  AST_LOAD_A: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 2'd1 |=> count_a == $past(wr_data) && !uf_a); // R3
  AST_LOAD_B: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 2'd2 |=> count_b == $past(wr_data) && !uf_b); // R3
  AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick && !(wr_en && wr_addr == 2'd1) |=> $stable(count_a)); // R6
  AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick && !(wr_en && wr_addr == 2'd2) |=> $stable(count_b)); // R6
  AST_WRAP_A: assert property (@(posedge clk) disable iff (!rst_n)
    uf_a && !$past(ctrl[4]) |-> count_a == '1); // R7
  AST_WRAP_B: assert property (@(posedge clk) disable iff (!rst_n)
    uf_b && !$past(ctrl[6]) |-> count_b == '1); // R7
  AST_UF_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
    uf_a |-> $past(count_a) == '0 && $past(ref_tick)); // R9
  AST_UF_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
    uf_b |-> $past(count_b) == '0 && $past(ref_tick)); // R9
endmodule

bind dual_timer dual_timer_chk #(.CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .ctrl(ctrl_q),
  .count_a(count_a), .count_b(count_b), .uf_a(uf_a), .uf_b(uf_b));

// File: tb/dual_timer_test.sv
module dual_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data, count_a, count_b;
  logic        uf_a, uf_b;
  int total = 0, bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  dual_timer uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .count_a(count_a), .count_b(count_b),
    .uf_a(uf_a), .uf_b(uf_b));

  // {we, addr, data, tick, exp_a, exp_b, exp_uf_a, exp_uf_b}
  localparam int NV = 14;
  localparam logic [53:0] VEC [NV] = '{
    {1'b1, 2'd0, 16'h00E0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R4 ctrl: A free direct, B prescale direct
    {1'b1, 2'd1, 16'h0003, 1'b0, 16'h0003, 16'h0000, 1'b0, 1'b0}, // R3
    {1'b1, 2'd2, 16'h0002, 1'b1, 16'h0002, 16'h0002, 1'b0, 1'b0}, // R3 load beats tick
    {1'b0, 2'd0, 16'h0000, 1'b1, 16'h0001, 16'h0001, 1'b0, 1'b0}, // R4
    {1'b0, 2'd0, 16'h0000, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R4
    {1'b0, 2'd0, 16'h0000, 1'b1, 16'hFFFF, 16'h0002, 1'b1, 1'b1}, // R7 R8
    {1'b0, 2'd0, 16'h0000, 1'b0, 16'hFFFF, 16'h0002, 1'b0, 1'b0}, // R6 R9
    {1'b0, 2'd0, 16'h0000, 1'b1, 16'hFFFE, 16'h0001, 1'b0, 1'b0}, // R4
    {1'b0, 2'd0, 16'h0000, 1'b1, 16'hFFFD, 16'h0000, 1'b0, 1'b0}, // R4
    {1'b0, 2'd0, 16'h0000, 1'b1, 16'hFFFC, 16'h0002, 1'b0, 1'b1}, // R10
    {1'b1, 2'd1, 16'h0000, 1'b1, 16'h0000, 16'h0001, 1'b0, 1'b0}, // R3
    {1'b1, 2'd0, 16'h00F0, 1'b0, 16'h0000, 16'h0001, 1'b0, 1'b0}, // R8 A to prescale
    {1'b0, 2'd0, 16'h0000, 1'b1, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R8 reload of 0
    {1'b0, 2'd0, 16'h0000, 1'b1, 16'h0000, 16'h0002, 1'b1, 1'b1}  // R8 R10
  };
  localparam int VREQ [NV] = '{4, 3, 3, 4, 4, 7, 6, 4, 4, 10, 3, 8, 8, 10};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [15:0] d, input logic t);
    wr_en = we; wr_addr = a; wr_data = d; ref_tick = t;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; ref_tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    do_reset();
    check("R1 count_a", count_a, 16'h0);
    check("R1 count_b", count_b, 16'h0);
    check("R1 uf", {14'd0, uf_a, uf_b}, 16'h0);
    rd_addr = 2'd0; #1 check("R1 ctrl", rd_data, 16'h0);
    rd_addr = 2'd1; #1 check("R1 load a", rd_data, 16'h0);
    rd_addr = 2'd2; #1 check("R1 load b", rd_data, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [53:0] v;
      v = VEC[i];
      step(v[53], v[52:51], v[50:35], v[34]);
      check($sformatf("R%0d vec %0d count_a", VREQ[i], i), count_a, v[33:18]);
      check($sformatf("R%0d vec %0d count_b", VREQ[i], i), count_b, v[17:2]);
      check($sformatf("R%0d vec %0d uf", VREQ[i], i), {14'd0, uf_a, uf_b}, {14'd0, v[1], v[0]});
    end

    rd_addr = 2'd0; #1 check("R2 ctrl read", rd_data, 16'h00F0);
    rd_addr = 2'd1; #1 check("R2 load a read", rd_data, 16'h0000);
    rd_addr = 2'd2; #1 check("R2 load b read", rd_data, 16'h0002);
    rd_addr = 2'd3; #1 check("R2 spare read", rd_data, 16'h0000);
    step(1'b1, 2'd0, 16'hFF3C, 1'b0);
    rd_addr = 2'd0; #1 check("R2 ctrl upper zero", rd_data, 16'h003C);

    // R5: divided tick after a fresh reset clears the prescaler
    do_reset();
    step(1'b1, 2'd1, 16'd10, 1'b0);
    step(1'b1, 2'd2, 16'd5, 1'b0);
    for (int i = 0; i < 255; i++) step(1'b0, 2'd0, 16'h0, 1'b1);
    check("R5 a after 255", count_a, 16'd10);
    check("R5 b after 255", count_b, 16'd5);
    step(1'b0, 2'd0, 16'h0, 1'b1);
    check("R5 a after 256", count_a, 16'd9);
    check("R5 b after 256", count_b, 16'd4);
    step(1'b1, 2'd0, 16'h0080, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 2'd0, 16'h0, 1'b1);
    check("R5 R10 a divided holds", count_a, 16'd9);
    check("R4 R10 b direct", count_b, 16'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule